// File: doc/BRIEF.md
# Run-Time Configurable Serial Transmitter with Clear-to-Send Gating

This block serializes words of up to nine bits onto an asynchronous serial line. Software-side logic writes a word into a one-entry holding buffer. When the start conditions hold, the word moves into a shift register and is sent as a complete frame: one start bit, the data bits, an optional parity bit, and one or two stop bits. The frame format is taken from live control inputs each time a word moves into the shift register.

A built-in divider sets the bit period from an 8-bit divisor. Two inversion options are available. One flips only the data bits. The other flips the whole line. A clear-to-send input can hold off the start of new frames. A single interrupt pulse can be tied either to the buffer-to-shifter transfer or to the end of the last stop bit. If the buffer is refilled while a frame is in flight, the next frame follows directly, with no idle time between frames.

Top module: `cfg_uart_tx`

## Requirements
- R1: While rst_ni is low and after it is released with no write, txd_o is high (line_inv_i low), buf_empty_o is high and irq_o is low.
- R2: Every bit of a frame lasts exactly 16*(baud_div_i+1) clock cycles. The first bit is a start bit at logic 0, and it drives the line from the clock edge that moves the word into the shift register.
- R3: char_len_i selects the number of data bits: 0 gives 7, 1 gives 8, and 2 or 3 gives 9. Buffer bits above the selected length are not sent.
- R4: parity_mode_i selects the parity: 1 gives even, 2 gives odd, and 0 or 3 gives no parity bit. The parity bit directly follows the data bits. It is computed over the data bits as they appear on the line, so that the count of ones in data plus parity is even (mode 1) or odd (mode 2).
- R5: two_stop_i=0 ends the frame with one stop bit at logic 1. two_stop_i=1 ends it with two.
- R6: A word leaves the buffer only when tx_en_i is high, the buffer holds data, and either cts_en_i is low or cts_i is low. While cts_en_i is low, cts_i has no effect.
- R7: With irq_on_done_i=0, irq_o is high for exactly one cycle, in the cycle after the transfer edge. buf_empty_o goes high in that same cycle.
- R8: With irq_on_done_i=1, irq_o is high for exactly one cycle, in the cycle after the last stop bit ends.
- R9: msb_first_i=0 sends data bit 0 first. msb_first_i=1 sends bit (length-1) first.
- R10: data_inv_i=1 inverts the data bits only. The start and stop bits keep their normal levels.
- R11: line_inv_i=1 inverts txd_o at all times, including the idle level, the start bit and the stop bits.
- R12: If the buffer holds data and the start conditions hold when the last stop bit ends, the next start bit begins on that same edge, with no idle cycle in between.
- R13: Dropping tx_en_i or raising cts_i (with cts_en_i=1) during a frame does not shorten it. Only the next transfer is held off.
- R14: A write while the buffer is full replaces the buffered word. The frame sent carries the last word written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, already prescaled |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe into the holding buffer |
| wr_data_i | input | 9 | Word to transmit |
| tx_en_i | input | 1 | Transmit enable |
| char_len_i | input | 2 | Data length select |
| parity_mode_i | input | 2 | Parity select |
| two_stop_i | input | 1 | Two stop bits when high |
| msb_first_i | input | 1 | Bit order select |
| data_inv_i | input | 1 | Invert data bits only |
| line_inv_i | input | 1 | Invert the whole serial output |
| irq_on_done_i | input | 1 | Interrupt timing select |
| cts_en_i | input | 1 | Enable clear-to-send gating |
| cts_i | input | 1 | Clear to send, active low |
| baud_div_i | input | 8 | Bit-period divisor n |
| txd_o | output | 1 | Serial output |
| buf_empty_o | output | 1 | Holding buffer empty |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The hardest state to reach is a word that is waiting in the holding buffer at the exact edge where the previous frame's last stop bit ends, both with the gate open (a seamless restart) and with it closed in mid-frame (a held start). The bench reaches this state by writing the second word and toggling tx_en_i and cts_i at chosen cycle offsets inside the first frame. It then compares the line on every cycle across the frame boundary. Every format combination at the shortest bit period is covered in a full sweep, with each line cycle compared against a frame assembled arithmetically in the bench.

// File: rtl/cfg_uart_tx_pkg.sv
package cfg_uart_tx_pkg;
  localparam int MAX_DATA_W = 9;
  localparam int OVS        = 16;
  localparam int DIV_W      = 8;
  localparam int FRAME_W    = 1 + MAX_DATA_W + 1 + 2;
  localparam int CNT_W      = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    LEN_7 = 2'd0,
    LEN_8 = 2'd1,
    LEN_9 = 2'd2,
    LEN_9B = 2'd3
  } char_len_e;

  typedef enum logic [1:0] {
    PAR_NONE  = 2'd0,
    PAR_EVEN  = 2'd1,
    PAR_ODD   = 2'd2,
    PAR_NONEB = 2'd3
  } parity_e;

  typedef struct packed {
    char_len_e len;
    parity_e   par;
    logic      two_stop;
    logic      msb_first;
    logic      data_inv;
  } fmt_t;
endpackage

// File: rtl/cfg_uart_tx_baud.sv
module cfg_uart_tx_baud #(
  parameter int DIV_W = 8,
  parameter int OVS   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             bit_end_o
);
  localparam int OVS_W = $clog2(OVS);

  logic [DIV_W-1:0] div_cnt_q;
  logic [OVS_W-1:0] ovs_cnt_q;
  logic             div_wrap;

  assign div_wrap  = (div_cnt_q == div_i);
  assign bit_end_o = run_i && div_wrap && (ovs_cnt_q == OVS_W'(OVS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_cnt_q <= '0;
      ovs_cnt_q <= '0;
    end else if (clear_i || !run_i) begin
      div_cnt_q <= '0;
      ovs_cnt_q <= '0;
    end else if (div_wrap) begin
      div_cnt_q <= '0;
      ovs_cnt_q <= ovs_cnt_q + 1'b1;
    end else begin
      div_cnt_q <= div_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_uart_tx_framer.sv
module cfg_uart_tx_framer
  import cfg_uart_tx_pkg::*;
(
  input  logic [MAX_DATA_W-1:0] data_i,
  input  fmt_t                  fmt_i,
  output logic [FRAME_W-1:0]    frame_o,
  output logic [CNT_W-1:0]      len_o
);
  localparam int IDX_W  = $clog2(MAX_DATA_W);
  localparam int FIDX_W = $clog2(FRAME_W);

  int                    n_data;
  logic                  par_en;
  logic                  par_bit;
  logic [IDX_W-1:0]      src;
  logic [MAX_DATA_W-1:0] dbits;

  always_comb begin
    case (fmt_i.len)
      LEN_7:   n_data = 7;
      LEN_8:   n_data = 8;
      default: n_data = 9;
    endcase
    par_en = (fmt_i.par == PAR_EVEN) || (fmt_i.par == PAR_ODD);

    // line-order data bits, data inversion applied, unused bits zero
    dbits = '0;
    src   = '0;
    for (int i = 0; i < MAX_DATA_W; i++) begin
      if (i < n_data) begin
        src      = fmt_i.msb_first ? IDX_W'(n_data - 1 - i) : IDX_W'(i);
        dbits[i] = data_i[src] ^ fmt_i.data_inv;
      end
    end
    par_bit = (^dbits) ^ (fmt_i.par == PAR_ODD);

    // stop bits come from the all-ones fill
    frame_o    = '1;
    frame_o[0] = 1'b0;
    for (int i = 0; i < MAX_DATA_W; i++) begin
      if (i < n_data) frame_o[FIDX_W'(i + 1)] = dbits[i];
    end
    if (par_en) frame_o[FIDX_W'(n_data + 1)] = par_bit;

    len_o = CNT_W'(1 + n_data + (par_en ? 1 : 0) + (fmt_i.two_stop ? 2 : 1));
  end
endmodule

// File: rtl/cfg_uart_tx_shift.sv
module cfg_uart_tx_shift #(
  parameter int FRAME_W = 13,
  parameter int CNT_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   len_i,
  input  logic               bit_end_i,
  output logic               busy_o,
  output logic               line_o,
  output logic               last_o
);
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   left_q;
  logic               busy_q;

  assign busy_o = busy_q;
  assign line_o = busy_q ? sh_q[0] : 1'b1;
  assign last_o = busy_q && (left_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      sh_q   <= frame_i;
      left_q <= len_i;
      busy_q <= 1'b1;
    end else if (busy_q && bit_end_i) begin
      if (last_o) begin
        busy_q <= 1'b0;
        sh_q   <= '1;
        left_q <= '0;
      end else begin
        sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
        left_q <= left_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_uart_tx.sv
module cfg_uart_tx
  import cfg_uart_tx_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [MAX_DATA_W-1:0] wr_data_i,
  input  logic                  tx_en_i,
  input  logic [1:0]            char_len_i,
  input  logic [1:0]            parity_mode_i,
  input  logic                  two_stop_i,
  input  logic                  msb_first_i,
  input  logic                  data_inv_i,
  input  logic                  line_inv_i,
  input  logic                  irq_on_done_i,
  input  logic                  cts_en_i,
  input  logic                  cts_i,
  input  logic [DIV_W-1:0]      baud_div_i,
  output logic                  txd_o,
  output logic                  buf_empty_o,
  output logic                  irq_o
);
  fmt_t                  fmt;
  logic [MAX_DATA_W-1:0] hold_q;
  logic                  full_q;
  logic                  irq_q;
  logic [FRAME_W-1:0]    frame;
  logic [CNT_W-1:0]      frame_len;
  logic                  busy;
  logic                  last;
  logic                  line_raw;
  logic                  bit_end;
  logic                  frame_done;
  logic                  gate_open;
  logic                  load;

  assign fmt.len       = char_len_e'(char_len_i);
  assign fmt.par       = parity_e'(parity_mode_i);
  assign fmt.two_stop  = two_stop_i;
  assign fmt.msb_first = msb_first_i;
  assign fmt.data_inv  = data_inv_i;

  assign frame_done = bit_end && last;
  assign gate_open  = tx_en_i && full_q && (!cts_en_i || !cts_i);
  assign load       = gate_open && (!busy || frame_done);

  cfg_uart_tx_framer u_framer (
    .data_i  (hold_q),
    .fmt_i   (fmt),
    .frame_o (frame),
    .len_o   (frame_len)
  );

  cfg_uart_tx_baud #(
    .DIV_W (DIV_W),
    .OVS   (OVS)
  ) u_baud (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (load),
    .run_i     (busy),
    .div_i     (baud_div_i),
    .bit_end_o (bit_end)
  );

  cfg_uart_tx_shift #(
    .FRAME_W (FRAME_W),
    .CNT_W   (CNT_W)
  ) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .frame_i   (frame),
    .len_i     (frame_len),
    .bit_end_i (bit_end),
    .busy_o    (busy),
    .line_o    (line_raw),
    .last_o    (last)
  );

  // a same-cycle write wins over the transfer: the new word stays buffered
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      full_q <= 1'b0;
    end else if (wr_i) begin
      hold_q <= wr_data_i;
      full_q <= 1'b1;
    end else if (load) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_on_done_i ? frame_done : load;
  end

  assign txd_o       = line_raw ^ line_inv_i;
  assign buf_empty_o = !full_q;
  assign irq_o       = irq_q;
endmodule

// File: rtl/cfg_uart_tx_chk.sv
module cfg_uart_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_i,
  input logic tx_en_i,
  input logic cts_en_i,
  input logic cts_i,
  input logic line_inv_i,
  input logic irq_on_done_i,
  input logic txd_o,
  input logic buf_empty_o,
  input logic irq_o,
  input logic busy,
  input logic load,
  input logic frame_done
);
  assert_start_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |-> (tx_en_i && !buf_empty_o && (!cts_en_i || !cts_i)));

  assert_empty_after_xfer_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && !wr_i) |=> buf_empty_o);

  assert_idle_level_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !load) |=> (!busy -> (txd_o != line_inv_i)));

  assert_start_bit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && $stable(line_inv_i)) |=> (busy && (txd_o == line_inv_i)));

  assert_frame_kept_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !frame_done) |=> busy);

  assert_irq_on_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && $past(irq_on_done_i)) |-> $past(frame_done));

  assert_irq_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_no_gap_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done && load) |=> busy);
endmodule

bind cfg_uart_tx cfg_uart_tx_chk chk_i (.*);

// File: tb/cfg_uart_tx_tb_top.sv
`timescale 1ns/1ps
module cfg_uart_tx_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0;
  logic [8:0] wr_data_i = '0;
  logic       tx_en_i = 1'b1;
  logic [1:0] char_len_i = 2'd1;
  logic [1:0] parity_mode_i = 2'd0;
  logic       two_stop_i = 1'b0;
  logic       msb_first_i = 1'b0;
  logic       data_inv_i = 1'b0;
  logic       line_inv_i = 1'b0;
  logic       irq_on_done_i = 1'b0;
  logic       cts_en_i = 1'b0;
  logic       cts_i = 1'b0;
  logic [7:0] baud_div_i = '0;
  logic       txd_o, buf_empty_o, irq_o;

  int n_vec = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  cfg_uart_tx dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // expected frame, bit 0 = first on the line (before line inversion)
  task automatic build(input logic [8:0] d, output logic [12:0] v, output int n,
                       output int nd, output bit pe);
    int ones = 0;
    int pos = 0;
    v = '1;
    nd = (char_len_i == 2'd0) ? 7 : (char_len_i == 2'd1) ? 8 : 9;
    pe = (parity_mode_i == 2'd1) || (parity_mode_i == 2'd2);
    v[pos++] = 1'b0;
    for (int k = 0; k < nd; k++) begin
      logic b;
      b = (msb_first_i ? d[nd-1-k] : d[k]) ^ data_inv_i;
      ones += int'(b);
      v[pos++] = b;
    end
    if (pe) v[pos++] = (parity_mode_i == 2'd1) ? logic'(ones % 2) : logic'((ones + 1) % 2);
    n = pos + (two_stop_i ? 2 : 1);
  endtask

  function automatic string tag(input int idx, input int nd, input bit pe, input bit linv);
    string s;
    if (idx == 0) s = "R2";
    else if (idx <= nd) s = "R3/R9/R10";
    else if (pe && idx == nd + 1) s = "R4";
    else s = "R5";
    if (linv) s = {s, "/R11"};
    return s;
  endfunction

  // call at the negedge just after the transfer edge (j = 0); returns at j = n*P
  task automatic run_frame(input logic [12:0] v, input int n, input int nd, input bit pe,
                           input int wr_at, input logic [8:0] wr_val, input int hold_at);
    int p = 16 * (int'(baud_div_i) + 1);
    for (int j = 0; j < n * p; j++) begin
      int idx = j / p;
      logic e = v[idx] ^ line_inv_i;
      chk(txd_o === e, tag(idx, nd, pe, line_inv_i), int'(txd_o), int'(e));
      if (j == 0 && !irq_on_done_i) chk(irq_o === 1'b1, "R7 irq at transfer", int'(irq_o), 1);
      if (j == 1) chk(irq_o === 1'b0, "R7/R8 irq single", int'(irq_o), 0);
      if (j == wr_at) begin wr_i = 1'b1; wr_data_i = wr_val; end
      if (j == wr_at + 1) wr_i = 1'b0;
      if (j == hold_at) begin tx_en_i = 1'b0; cts_i = 1'b1; end
      @(negedge clk_i);
    end
    if (irq_on_done_i) chk(irq_o === 1'b1, "R8 irq at completion", int'(irq_o), 1);
  endtask

  // write one word while idle and send it; ends one cycle after the frame
  task automatic send(input logic [8:0] d);
    logic [12:0] v; int n, nd; bit pe;
    build(d, v, n, nd, pe);
    wr_i = 1'b1; wr_data_i = d;
    @(negedge clk_i); wr_i = 1'b0;
    chk(buf_empty_o === 1'b0, "R6 buffer held", int'(buf_empty_o), 0);
    @(negedge clk_i);
    chk(buf_empty_o === 1'b1, "R7 buffer emptied", int'(buf_empty_o), 1);
    run_frame(v, n, nd, pe, -5, '0, -5);
    chk(txd_o === ~line_inv_i, "R11 idle after frame", int'(txd_o), int'(~line_inv_i));
    @(negedge clk_i);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    logic [12:0] v1, v2; int n1, n2, nd1, nd2; bit pe1, pe2;
    repeat (3) @(negedge clk_i);
    chk(txd_o === 1'b1, "R1 reset line", int'(txd_o), 1);
    chk(buf_empty_o === 1'b1, "R1 reset empty", int'(buf_empty_o), 1);
    chk(irq_o === 1'b0, "R1 reset irq", int'(irq_o), 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    chk(txd_o === 1'b1 && buf_empty_o === 1'b1 && irq_o === 1'b0, "R1 after reset",
        int'({txd_o, buf_empty_o, irq_o}), 3'b110);

    // full format sweep at the shortest period; cts high but gating off (R6)
    cts_i = 1'b1;
    for (int c = 0; c < 144; c++) begin
      char_len_i    = 2'(c % 3);
      parity_mode_i = 2'((c / 3) % 3);
      two_stop_i    = 1'((c / 9) % 2);
      msb_first_i   = 1'((c / 18) % 2);
      data_inv_i    = 1'((c / 36) % 2);
      line_inv_i    = 1'((c / 72) % 2);
      irq_on_done_i = 1'(c % 2);
      @(negedge clk_i);
      send(9'h1A5);
      send(9'((c * 37 + 11) & 9'h1FF));
    end
    cts_i = 1'b0;
    line_inv_i = 1'b0; data_inv_i = 1'b0; msb_first_i = 1'b0;
    char_len_i = 2'd3; parity_mode_i = 2'd3; two_stop_i = 1'b0;
    @(negedge clk_i);
    send(9'h155); // reserved codes: 9 bits, no parity (R3, R4)

    // bit period for other divisors (R2)
    char_len_i = 2'd1; parity_mode_i = 2'd1;
    for (int k = 0; k < 3; k++) begin
      baud_div_i = (k == 0) ? 8'd1 : (k == 1) ? 8'd3 : 8'd6;
      @(negedge clk_i);
      send(9'h0C3);
    end
    baud_div_i = 8'd0;

    // enable gating (R6)
    irq_on_done_i = 1'b0;
    tx_en_i = 1'b0;
    @(negedge clk_i);
    wr_i = 1'b1; wr_data_i = 9'h03C;
    @(negedge clk_i); wr_i = 1'b0;
    repeat (40) begin
      @(negedge clk_i);
      chk(buf_empty_o === 1'b0 && txd_o === 1'b1, "R6 held by enable",
          int'({buf_empty_o, txd_o}), 2'b01);
    end
    // overwrite while full (R14)
    wr_i = 1'b1; wr_data_i = 9'h0A7;
    @(negedge clk_i); wr_i = 1'b0;
    tx_en_i = 1'b1;
    build(9'h0A7, v1, n1, nd1, pe1);
    @(negedge clk_i);
    chk(buf_empty_o === 1'b1, "R14 transfer of last word", int'(buf_empty_o), 1);
    run_frame(v1, n1, nd1, pe1, -5, '0, -5);
    @(negedge clk_i);

    // clear-to-send gating (R6)
    cts_en_i = 1'b1; cts_i = 1'b1;
    wr_i = 1'b1; wr_data_i = 9'h0F0;
    @(negedge clk_i); wr_i = 1'b0;
    repeat (40) begin
      @(negedge clk_i);
      chk(buf_empty_o === 1'b0 && txd_o === 1'b1, "R6 held by cts",
          int'({buf_empty_o, txd_o}), 2'b01);
    end
    cts_i = 1'b0;
    build(9'h0F0, v1, n1, nd1, pe1);
    @(negedge clk_i);
    chk(buf_empty_o === 1'b1, "R6 released by cts", int'(buf_empty_o), 1);
    run_frame(v1, n1, nd1, pe1, -5, '0, -5);
    @(negedge clk_i);

    // back-to-back frames (R12), both irq modes
    for (int m = 0; m < 2; m++) begin
      irq_on_done_i = 1'(m);
      build(9'h05A, v1, n1, nd1, pe1);
      build(9'h1C3, v2, n2, nd2, pe2);
      wr_i = 1'b1; wr_data_i = 9'h05A;
      @(negedge clk_i); wr_i = 1'b0;
      @(negedge clk_i);
      run_frame(v1, n1, nd1, pe1, 20, 9'h1C3, -5);
      chk(buf_empty_o === 1'b1, "R12 next word taken at once", int'(buf_empty_o), 1);
      run_frame(v2, n2, nd2, pe2, -5, '0, -5);
      chk(txd_o === 1'b1, "R12 idle after pair", int'(txd_o), 1);
      @(negedge clk_i);
    end

    // mid-frame hold-off (R13)
    irq_on_done_i = 1'b1;
    build(9'h033, v1, n1, nd1, pe1);
    build(9'h0CC, v2, n2, nd2, pe2);
    wr_i = 1'b1; wr_data_i = 9'h033;
    @(negedge clk_i); wr_i = 1'b0;
    @(negedge clk_i);
    run_frame(v1, n1, nd1, pe1, 10, 9'h0CC, 30);
    repeat (60) begin
      chk(buf_empty_o === 1'b0 && txd_o === 1'b1, "R13 next frame held",
          int'({buf_empty_o, txd_o}), 2'b01);
      @(negedge clk_i);
    end
    cts_i = 1'b0;
    @(negedge clk_i);
    tx_en_i = 1'b1;
    @(negedge clk_i);
    chk(buf_empty_o === 1'b1, "R13 released", int'(buf_empty_o), 1);
    run_frame(v2, n2, nd2, pe2, -5, '0, -5);
    @(negedge clk_i);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule